// File: doc/BRIEF.md
# Register Scoreboard and Operand Bypass Control

This block decides, cycle by cycle, whether the instruction at the issue stage of an in-order integer pipeline may issue. It also chooses where each source operand comes from. The register space holds 32 architectural 32-bit registers: indices 0 to 15 are the globals and indices 16 to 31 are the locals. The scoreboard treats both halves alike. Loads do not block the pipeline. When a load is accepted, the pending bit of its destination register is set. Later instructions that touch none of the pending registers keep issuing every cycle. An instruction that reads or writes a pending register is held until the load data for that register comes back on the load-return port. A separate pending flag tracks a condition-code result that is still being computed, so only instructions that use the condition code wait for it.

For each source there is a 2-bit select. It picks one of three inputs for the operand: the register-file read, the ALU result of the previous instruction (which is being written back in this cycle), or the load data returning in this cycle. A returning load frees its register in the return cycle itself. A dependent instruction can therefore issue in that same cycle, taking its operand from the load-return path. The number of outstanding loads is capped by a parameter.

Top module: `regsb_issue_ctl`

## Requirements
- R1: While reset is asserted, all register pending bits, the outstanding-load count and the condition-code pending flag are cleared. After reset, a load issues with `stall` low.
- R2: All 32 register indices are tracked the same way, including global index 0 and local index 31.
- R3: An accepted load (`iss_valid` high, `stall` low, `iss_is_load` high, `iss_dst_used` high) sets the pending bit of `iss_dst` from the next cycle. An accepted non-load leaves every pending bit unchanged.
- R4: With `iss_valid` high, `stall` is high when a used source or a used destination names a register that is effectively pending. A register is effectively pending when its pending bit is set and it is not being returned in this cycle.
- R5: An instruction whose registers are all effectively not pending issues with `stall` low, even while loads are outstanding.
- R6: A load return (`ld_ret_valid`, `ld_ret_tag`) clears the pending bit of its register. In that same cycle the register no longer causes a stall. A used source naming that register gets select 2 (load data), unless R7 applies.
- R7: A used source that equals `alu_wb_dst` while `alu_wb_valid` is high gets select 1 (ALU bypass). This takes priority over select 2, which takes priority over select 0 (register file). An unused source always gets select 0.
- R8: At most MAX_LOADS (default 2) loads are outstanding. A load meeting a full count stalls, unless a load returns in the same cycle. Returns may come back in any order.
- R9: If a load to register X is accepted in the same cycle that X returns, X is pending in the next cycle.
- R10: While the condition-code result is pending, an instruction that reads the condition code (`iss_cc_rd`) or starts a new late condition-code write (`iss_cc_wr`) stalls. `cc_done` clears the flag and releases those instructions in its own cycle. An accepted `iss_cc_wr` sets the flag, and the set wins over a `cc_done` in the same cycle.
- R11: `stall` is low whenever `iss_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | An instruction is presented for issue |
| iss_src_a | input | 5 | First source register index |
| iss_src_a_used | input | 1 | First source is read |
| iss_src_b | input | 5 | Second source register index |
| iss_src_b_used | input | 1 | Second source is read |
| iss_dst | input | 5 | Destination register index |
| iss_dst_used | input | 1 | Destination is written |
| iss_is_load | input | 1 | Instruction is a load |
| iss_cc_rd | input | 1 | Instruction reads the condition code |
| iss_cc_wr | input | 1 | Instruction produces a late condition code |
| ld_ret_valid | input | 1 | Load data returns this cycle |
| ld_ret_tag | input | 5 | Destination register of the returning load |
| alu_wb_valid | input | 1 | ALU result of the previous instruction is written back this cycle |
| alu_wb_dst | input | 5 | Destination register of that ALU result |
| cc_done | input | 1 | Late condition code is complete |
| stall | output | 1 | Hold the presented instruction |
| opa_sel | output | 2 | First operand source: 0 register file, 1 ALU bypass, 2 load return |
| opb_sel | output | 2 | Second operand source, same encoding |

## Verification
The assertions take for granted that a load return only carries the tag of a register that is currently pending, with at most one return per cycle. They also assume that the ALU writeback never targets a pending register, because the scoreboard would have held that instruction. In its random phase, the stimulus draws every return tag from the queue of outstanding loads kept by the reference model. It picks ALU writeback destinations only among registers the model shows as free. It raises `cc_done` only while the model holds a condition code pending. The directed part also drives a return and an ALU writeback to the same register at once, only to check the select priority of R7, while no instruction is presented.

// File: rtl/regsb_pkg.sv
package regsb_pkg;
  localparam int unsigned NUM_GLOBAL = 16;
  localparam int unsigned NUM_LOCAL  = 16;
  localparam int unsigned NUM_REGS   = NUM_GLOBAL + NUM_LOCAL;
  localparam int unsigned REG_IDX_W  = $clog2(NUM_REGS);
  localparam int unsigned NUM_SRC    = 2;

  typedef logic [REG_IDX_W-1:0] reg_idx_t;
  typedef logic [NUM_REGS-1:0]  reg_vec_t;

  typedef enum logic [1:0] {
    OPSRC_RF   = 2'd0,
    OPSRC_ALU  = 2'd1,
    OPSRC_LOAD = 2'd2
  } opsrc_e;

  // one-hot vector for a register index, all zero when not enabled
  function automatic reg_vec_t idx_mask(input reg_idx_t idx, input logic en);
    reg_vec_t m;
    m = '0;
    m[idx] = en;
    return m;
  endfunction

  // a register reference hits the scoreboard when used and pending
  function automatic logic ref_hits(input reg_vec_t pend, input reg_idx_t idx, input logic used);
    return used & pend[idx];
  endfunction

  // operand source choice: ALU bypass first, then load return, then file
  function automatic opsrc_e pick_src(input reg_idx_t src, input logic used,
                                      input logic alu_v, input reg_idx_t alu_d,
                                      input logic ld_v, input reg_idx_t ld_d);
    if (!used)                   return OPSRC_RF;
    else if (alu_v && alu_d == src) return OPSRC_ALU;
    else if (ld_v && ld_d == src)   return OPSRC_LOAD;
    else                         return OPSRC_RF;
  endfunction
endpackage

// File: rtl/regsb_pend_table.sv
module regsb_pend_table
  import regsb_pkg::*;
#(
  parameter int unsigned MAX_LOADS = 2,
  localparam int unsigned CNT_W = $clog2(MAX_LOADS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  reg_idx_t         set_idx,
  input  logic             clr_en,
  input  reg_idx_t         clr_idx,
  input  logic             cc_set,
  input  logic             cc_clr,
  output reg_vec_t         pend_q,
  output reg_vec_t         pend_eff,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_eff,
  output logic             cc_pend_q,
  output logic             cc_pend_eff,
  output logic             clr_hit
);
  reg_vec_t         set_mask;
  reg_vec_t         clr_mask;
  reg_vec_t         pend_nxt;
  logic [CNT_W-1:0] cnt_nxt;
  logic             cc_nxt;

  assign set_mask = idx_mask(set_idx, set_en);
  assign clr_mask = idx_mask(clr_idx, clr_en);
  // a return for a register that is not pending frees nothing
  assign clr_hit  = clr_en & pend_q[clr_idx];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_bit
    assign pend_eff[r] = pend_q[r] & ~clr_mask[r];
    // the set of a newly accepted load wins over a same-cycle clear
    assign pend_nxt[r] = set_mask[r] | pend_eff[r];
  end

  assign cnt_eff     = cnt_q - CNT_W'(clr_hit);
  assign cnt_nxt     = cnt_eff + CNT_W'(set_en);
  assign cc_pend_eff = cc_pend_q & ~cc_clr;
  assign cc_nxt      = cc_set | cc_pend_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= '0;
      cnt_q     <= '0;
      cc_pend_q <= 1'b0;
    end else begin
      pend_q    <= pend_nxt;
      cnt_q     <= cnt_nxt;
      cc_pend_q <= cc_nxt;
    end
  end
endmodule

// File: rtl/regsb_hazard.sv
module regsb_hazard
  import regsb_pkg::*;
#(
  parameter int unsigned MAX_LOADS = 2,
  localparam int unsigned CNT_W = $clog2(MAX_LOADS + 1)
) (
  input  logic             iss_valid,
  input  reg_idx_t         src_a,
  input  logic             src_a_used,
  input  reg_idx_t         src_b,
  input  logic             src_b_used,
  input  reg_idx_t         dst,
  input  logic             dst_used,
  input  logic             is_load,
  input  logic             cc_rd,
  input  logic             cc_wr,
  input  reg_vec_t         pend_eff,
  input  logic [CNT_W-1:0] cnt_eff,
  input  logic             cc_pend_eff,
  output logic             raw_hit,
  output logic             waw_hit,
  output logic             cap_hit,
  output logic             cc_hit,
  output logic             stall
);
  assign raw_hit = ref_hits(pend_eff, src_a, src_a_used) |
                   ref_hits(pend_eff, src_b, src_b_used);
  assign waw_hit = ref_hits(pend_eff, dst, dst_used);
  assign cap_hit = is_load & (cnt_eff >= CNT_W'(MAX_LOADS));
  assign cc_hit  = (cc_rd | cc_wr) & cc_pend_eff;
  assign stall   = iss_valid & (raw_hit | waw_hit | cap_hit | cc_hit);
endmodule

// File: rtl/regsb_opsel.sv
module regsb_opsel
  import regsb_pkg::*;
(
  input  reg_idx_t    src,
  input  logic        used,
  input  logic        alu_v,
  input  reg_idx_t    alu_d,
  input  logic        ld_v,
  input  reg_idx_t    ld_d,
  output logic [1:0]  sel
);
  opsrc_e choice;
  assign choice = pick_src(src, used, alu_v, alu_d, ld_v, ld_d);
  assign sel    = choice;
endmodule

// File: rtl/regsb_issue_ctl.sv
module regsb_issue_ctl
  import regsb_pkg::*;
#(
  parameter int unsigned MAX_LOADS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       iss_valid,
  input  logic [4:0] iss_src_a,
  input  logic       iss_src_a_used,
  input  logic [4:0] iss_src_b,
  input  logic       iss_src_b_used,
  input  logic [4:0] iss_dst,
  input  logic       iss_dst_used,
  input  logic       iss_is_load,
  input  logic       iss_cc_rd,
  input  logic       iss_cc_wr,
  input  logic       ld_ret_valid,
  input  logic [4:0] ld_ret_tag,
  input  logic       alu_wb_valid,
  input  logic [4:0] alu_wb_dst,
  input  logic       cc_done,
  output logic       stall,
  output logic [1:0] opa_sel,
  output logic [1:0] opb_sel
);
  localparam int unsigned CNT_W = $clog2(MAX_LOADS + 1);

  reg_vec_t         pend_q;
  reg_vec_t         pend_eff;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_eff;
  logic             cc_pend_q;
  logic             cc_pend_eff;
  logic             clr_hit;
  logic             raw_hit;
  logic             waw_hit;
  logic             cap_hit;
  logic             cc_hit;
  logic             accept;
  logic             load_set;
  logic             cc_set;

  reg_idx_t   src_idx  [NUM_SRC];
  logic       src_used [NUM_SRC];
  logic [1:0] src_sel  [NUM_SRC];

  assign accept   = iss_valid & ~stall;
  assign load_set = accept & iss_is_load & iss_dst_used;
  assign cc_set   = accept & iss_cc_wr;

  regsb_pend_table #(.MAX_LOADS(MAX_LOADS)) table_i (
    .clk(clk), .rst_n(rst_n),
    .set_en(load_set), .set_idx(iss_dst),
    .clr_en(ld_ret_valid), .clr_idx(ld_ret_tag),
    .cc_set(cc_set), .cc_clr(cc_done),
    .pend_q(pend_q), .pend_eff(pend_eff),
    .cnt_q(cnt_q), .cnt_eff(cnt_eff),
    .cc_pend_q(cc_pend_q), .cc_pend_eff(cc_pend_eff),
    .clr_hit(clr_hit)
  );

  regsb_hazard #(.MAX_LOADS(MAX_LOADS)) hazard_i (
    .iss_valid(iss_valid),
    .src_a(iss_src_a), .src_a_used(iss_src_a_used),
    .src_b(iss_src_b), .src_b_used(iss_src_b_used),
    .dst(iss_dst), .dst_used(iss_dst_used),
    .is_load(iss_is_load), .cc_rd(iss_cc_rd), .cc_wr(iss_cc_wr),
    .pend_eff(pend_eff), .cnt_eff(cnt_eff), .cc_pend_eff(cc_pend_eff),
    .raw_hit(raw_hit), .waw_hit(waw_hit), .cap_hit(cap_hit), .cc_hit(cc_hit),
    .stall(stall)
  );

  assign src_idx[0]  = iss_src_a;
  assign src_used[0] = iss_src_a_used;
  assign src_idx[1]  = iss_src_b;
  assign src_used[1] = iss_src_b_used;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    regsb_opsel opsel_i (
      .src(src_idx[s]), .used(src_used[s]),
      .alu_v(alu_wb_valid), .alu_d(alu_wb_dst),
      .ld_v(ld_ret_valid), .ld_d(ld_ret_tag),
      .sel(src_sel[s])
    );
  end

  assign opa_sel = src_sel[0];
  assign opb_sel = src_sel[1];
endmodule

// File: rtl/regsb_issue_ctl_chk.sv
module regsb_issue_ctl_chk
  import regsb_pkg::*;
#(
  parameter int unsigned MAX_LOADS = 2,
  localparam int unsigned CNT_W = $clog2(MAX_LOADS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             iss_valid,
  input logic [4:0]       iss_dst,
  input logic             iss_dst_used,
  input logic             iss_is_load,
  input logic             iss_cc_wr,
  input logic             ld_ret_valid,
  input logic [4:0]       ld_ret_tag,
  input logic             alu_wb_valid,
  input logic             stall,
  input logic [1:0]       opa_sel,
  input logic [1:0]       opb_sel,
  input logic             accept,
  input reg_vec_t         pend_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             cc_pend_q
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (pend_q == '0 && cnt_q == '0 && !cc_pend_q));

  // R8
  count_tracks_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == CNT_W'($countones(pend_q)));

  // R8
  load_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(MAX_LOADS));

  // R3
  load_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && iss_is_load && iss_dst_used) |=> pend_q[$past(iss_dst)]);

  // R6
  return_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_ret_valid && !(accept && iss_is_load && iss_dst_used && iss_dst == ld_ret_tag))
      |=> !pend_q[$past(ld_ret_tag)]);

  // R10
  cc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && iss_cc_wr) |=> cc_pend_q);

  // R11
  idle_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_valid |-> !stall);

  // R7
  alu_sel_needs_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opa_sel == 2'd1 || opb_sel == 2'd1) |-> alu_wb_valid);

  // R6
  load_sel_needs_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opa_sel == 2'd2 || opb_sel == 2'd2) |-> ld_ret_valid);
endmodule

bind regsb_issue_ctl regsb_issue_ctl_chk #(.MAX_LOADS(MAX_LOADS)) chk_i (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid),
  .iss_dst(iss_dst), .iss_dst_used(iss_dst_used), .iss_is_load(iss_is_load),
  .iss_cc_wr(iss_cc_wr), .ld_ret_valid(ld_ret_valid), .ld_ret_tag(ld_ret_tag),
  .alu_wb_valid(alu_wb_valid), .stall(stall), .opa_sel(opa_sel), .opb_sel(opb_sel),
  .accept(accept), .pend_q(pend_q), .cnt_q(cnt_q), .cc_pend_q(cc_pend_q)
);

// File: tb/regsb_issue_ctl_tb_top.sv
module regsb_issue_ctl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       iss_valid = 1'b0;
  logic [4:0] iss_src_a = '0;
  logic       iss_src_a_used = 1'b0;
  logic [4:0] iss_src_b = '0;
  logic       iss_src_b_used = 1'b0;
  logic [4:0] iss_dst = '0;
  logic       iss_dst_used = 1'b0;
  logic       iss_is_load = 1'b0;
  logic       iss_cc_rd = 1'b0;
  logic       iss_cc_wr = 1'b0;
  logic       ld_ret_valid = 1'b0;
  logic [4:0] ld_ret_tag = '0;
  logic       alu_wb_valid = 1'b0;
  logic [4:0] alu_wb_dst = '0;
  logic       cc_done = 1'b0;
  logic       stall;
  logic [1:0] opa_sel;
  logic [1:0] opb_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference state: outstanding load tags and the condition-code flag
  int m_q[$];
  bit m_cc;

  always #4 clk = ~clk;

  regsb_issue_ctl dut_i (.*);

  function automatic bit m_pend(int r);
    foreach (m_q[i]) if (m_q[i] == r) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit m_busy(int r);
    return m_pend(r) && !(ld_ret_valid && int'(ld_ret_tag) == r);
  endfunction

  function automatic int m_sel(int s, bit u);
    if (!u) return 0;
    if (alu_wb_valid && int'(alu_wb_dst) == s) return 1;
    if (ld_ret_valid && int'(ld_ret_tag) == s) return 2;
    return 0;
  endfunction

  function automatic bit m_stall();
    int live;
    live = m_q.size();
    if (ld_ret_valid && m_pend(int'(ld_ret_tag))) live--;
    if (!iss_valid) return 1'b0;
    if (iss_src_a_used && m_busy(int'(iss_src_a))) return 1'b1;
    if (iss_src_b_used && m_busy(int'(iss_src_b))) return 1'b1;
    if (iss_dst_used && m_busy(int'(iss_dst))) return 1'b1;
    if (iss_is_load && live >= 2) return 1'b1;
    if ((iss_cc_rd || iss_cc_wr) && m_cc && !cc_done) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // compare this cycle, then advance the model across the clock edge
  task automatic tick(string req, int lit_stall);
    bit acc;
    int ea, eb;
    #1;
    ea = m_sel(int'(iss_src_a), iss_src_a_used);
    eb = m_sel(int'(iss_src_b), iss_src_b_used);
    chk(req, int'(stall), int'(m_stall()));
    if (lit_stall >= 0) chk(req, int'(stall), lit_stall);
    chk(ea == 2 ? "R6" : "R7", int'(opa_sel), ea);
    chk(eb == 2 ? "R6" : "R7", int'(opb_sel), eb);
    acc = iss_valid && !m_stall();
    @(posedge clk);
    if (ld_ret_valid)
      foreach (m_q[i]) if (m_q[i] == int'(ld_ret_tag)) begin m_q.delete(i); break; end
    if (acc && iss_is_load && iss_dst_used) m_q.push_back(int'(iss_dst));
    m_cc = (m_cc && !cc_done) || (acc && iss_cc_wr);
    @(negedge clk);
  endtask

  task automatic clear_in();
    iss_valid = 0; iss_src_a_used = 0; iss_src_b_used = 0; iss_dst_used = 0;
    iss_is_load = 0; iss_cc_rd = 0; iss_cc_wr = 0; ld_ret_valid = 0;
    alu_wb_valid = 0; cc_done = 0;
  endtask

  task automatic put(int a, int b, int d, bit ld);
    clear_in();
    iss_valid = 1; iss_src_a = 5'(a); iss_src_b = 5'(b); iss_dst = 5'(d);
    iss_src_a_used = !ld; iss_src_b_used = !ld; iss_dst_used = 1; iss_is_load = ld;
    if (ld) begin iss_src_a_used = 1; end
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    clear_in();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_q.delete(); m_cc = 0;
    // R1: fresh state, a load to r5 (address in r10) issues
    tick("R1", 0);
    put(10, 0, 5, 1); tick("R1", 0);
    // R5: independent ALU op while r5 is outstanding
    put(2, 3, 1, 0); tick("R5", 0);
    // R4: RAW on r5 held for several cycles
    put(5, 1, 6, 0); alu_wb_valid = 1; alu_wb_dst = 5'd1; tick("R4", 1);
    put(5, 1, 6, 0); tick("R4", 1);
    // R4: WAW on r5
    put(7, 8, 5, 0); tick("R4", 1);
    // R6: return r5 releases the dependent op in that cycle
    put(5, 1, 6, 0); ld_ret_valid = 1; ld_ret_tag = 5'd5;
    alu_wb_valid = 1; alu_wb_dst = 5'd1; tick("R6", 0);
    // R2 and R8: loads to r31 and r0, third load held
    put(9, 0, 31, 1); tick("R2", 0);
    put(9, 0, 0, 1); tick("R2", 0);
    put(2, 0, 31, 0); iss_src_a = 5'd31; tick("R2", 1);
    put(9, 0, 7, 1); tick("R8", 1);
    // R8: out-of-order return of r0 lets the third load go
    put(9, 0, 7, 1); ld_ret_valid = 1; ld_ret_tag = 5'd0; tick("R8", 0);
    // R9: reload r31 in its return cycle, stays pending
    put(9, 0, 31, 1); ld_ret_valid = 1; ld_ret_tag = 5'd31; tick("R9", 0);
    put(31, 2, 3, 0); tick("R9", 1);
    // R3: accepted non-load leaves r12 free
    put(2, 3, 12, 0); tick("R3", 0);
    put(12, 12, 13, 0); tick("R3", 0);
    // R11: nothing presented while r31 pending
    put(31, 31, 31, 0); iss_valid = 0; tick("R11", 0);
    // R7: ALU bypass beats a load return to the same register (no issue)
    clear_in(); iss_src_a = 5'd7; iss_src_a_used = 1;
    alu_wb_valid = 1; alu_wb_dst = 5'd7; ld_ret_valid = 1; ld_ret_tag = 5'd7;
    #1; chk("R7", int'(opa_sel), 1); #1; tick("R7", 0);
    clear_in(); ld_ret_valid = 1; ld_ret_tag = 5'd31; tick("R6", 0);
    // R10: condition-code scoreboard
    put(1, 2, 3, 0); iss_cc_wr = 1; tick("R10", 0);
    put(1, 2, 4, 0); iss_cc_rd = 1; tick("R10", 1);
    put(1, 2, 4, 0); tick("R10", 0);
    put(1, 2, 4, 0); iss_cc_rd = 1; cc_done = 1; tick("R10", 0);
    put(1, 2, 4, 0); iss_cc_rd = 1; tick("R10", 0);
    // random phase within the input contract
    for (int n = 0; n < 3000; n++) begin
      clear_in();
      iss_valid = ($urandom_range(0, 3) != 0);
      iss_src_a = 5'($urandom_range(0, 31)); iss_src_a_used = 1'($urandom_range(0, 1));
      iss_src_b = 5'($urandom_range(0, 31)); iss_src_b_used = 1'($urandom_range(0, 1));
      iss_dst   = 5'($urandom_range(0, 31)); iss_dst_used   = ($urandom_range(0, 4) != 0);
      iss_is_load = ($urandom_range(0, 2) == 0);
      iss_cc_rd = ($urandom_range(0, 7) == 0);
      iss_cc_wr = ($urandom_range(0, 9) == 0);
      if (m_q.size() > 0 && $urandom_range(0, 2) == 0) begin
        ld_ret_valid = 1;
        ld_ret_tag = 5'(m_q[$urandom_range(0, m_q.size() - 1)]);
      end
      if ($urandom_range(0, 1) == 1) begin
        for (int t = 0; t < 8; t++) begin
          alu_wb_dst = 5'($urandom_range(0, 31));
          if (!m_pend(int'(alu_wb_dst))) begin alu_wb_valid = 1; break; end
        end
      end
      if (m_cc && $urandom_range(0, 2) == 0) cc_done = 1;
      tick("R4", -1);
    end
    done = 1'b1;
    finish_run();
  end
endmodule